// File: doc/BRIEF.md
# Linearized Graph Global-Context Layer

This block computes one layer of a linearized interaction network for a whole graph at once. Every cycle it may accept a graph of `N_O` nodes, each carrying `P` signed fixed-point features. It returns `N_O` updated embeddings of width `D_E`. Each node is first mapped through a constant dense matrix that all nodes share. The projected vectors are then averaged over the graph. A second constant matrix turns that average into one context vector. That context vector and a constant bias are added to every node's own projection. No stage computes anything per pair of nodes, so the cost grows linearly with the node count.

The datapath has four register stages: projection, pooling, context and merge. Every weight is a synthesis-time constant, and each product is built from shifts, adds and subtracts only. The node count must be a power of two, so the mean is an arithmetic right shift. The interface is a valid/data pair on each side, with no stall path.

Top module: `graph_ctx_layer`

## Requirements
- R1: Node i feature p is taken as a signed 8-bit value from `in_feat[(i*2+p)*8 +: 8]`. Its projection is X[i][0] = 3*f0 - 2*f1 and X[i][1] = f0 + 5*f1.
- R2: The pooled vector is the sum over all four nodes of X[i][d], shifted right arithmetically by two bits. The result is rounded toward negative infinity, so a sum of -3 gives -1.
- R3: The context vector is G[0] = 2*M[0] - M[1] and G[1] = -3*M[0] + 4*M[1], where M is the pooled vector.
- R4: Each output is E[i][d] = X[i][d] + G[d] + C[d] with C = (5, -7). The same G is added to every node, so a nonzero feature on one node changes the outputs of every node. Lane (i,d) is placed at `out_emb[(i*2+d)*10 +: 10]`.
- R5: Each output lane saturates to the signed 10-bit range. A value above 511 becomes 511 and a value below -512 becomes -512.
- R6: Graphs presented on consecutive cycles each produce their own correct result on consecutive cycles. The initiation interval is one cycle.
- R7: `out_valid` equals `in_valid` delayed by exactly four clock cycles. It is low in the cycles that follow idle input cycles.
- R8: While `rst` is sampled high, the block clears `out_valid` and `out_emb` to zero at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_feat` as carrying a graph this cycle |
| in_feat | input | N_O*P*IN_W | Node features, node-major, signed |
| out_valid | output | 1 | Marks `out_emb` as carrying a result |
| out_emb | output | N_O*D_E*OUT_W | Updated node embeddings, node-major, saturated |

## Verification
Two things can happen in the same cycle. A new graph can be accepted while the result of an earlier graph leaves through the saturating merge stage. The bench provokes this by streaming its vector table with no gaps, so graphs that saturate in both directions sit next to graphs whose mean depends on rounding toward negative infinity. Each result is compared four cycles after its graph entered, against a value the bench computes itself from the stated weights. Any error that passes state from one graph to the next therefore shows up as a wrong lane.

// File: rtl/graph_ctx_layer.sv
`timescale 1ns/1ps
module graph_ctx_layer #(
  parameter int N_O   = 4,
  parameter int P     = 2,
  parameter int D_E   = 2,
  parameter int IN_W  = 8,
  parameter int W_W   = 4,
  parameter int B_W   = 8,
  parameter int OUT_W = 10,
  parameter logic [D_E*P*W_W-1:0]   W1   = 16'h51E3,
  parameter logic [D_E*D_E*W_W-1:0] W2   = 16'h4DF2,
  parameter logic [D_E*B_W-1:0]     BIAS = 16'hF905
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [N_O*P*IN_W-1:0]    in_feat,
  output logic                     out_valid,
  output logic [N_O*D_E*OUT_W-1:0] out_emb
);
  localparam int LG_N = $clog2(N_O);
  localparam int XW   = IN_W + W_W + $clog2(P) + 1;
  localparam int SW   = XW + LG_N;
  localparam int GW   = XW + W_W + $clog2(D_E) + 1;
  localparam int FW   = GW + B_W + 2;
  localparam int LAT  = 4;
  localparam logic signed [FW-1:0] SAT_HI = {{(FW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [FW-1:0] SAT_LO = {{(FW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  function automatic logic signed [FW-1:0] shadd(input logic signed [FW-1:0] x,
                                                 input logic [W_W-1:0] w);
    logic signed [FW-1:0] acc;
    acc = '0;
    for (int b = 0; b < W_W-1; b++)
      if (w[b]) acc = acc + (x <<< b);
    if (w[W_W-1]) acc = acc - (x <<< (W_W-1));
    return acc;
  endfunction

  logic [LAT-1:0]            v_q;
  logic signed [XW-1:0]      x_c   [N_O][D_E];
  logic signed [XW-1:0]      x_q   [N_O][D_E];
  logic signed [XW-1:0]      x_d1  [N_O][D_E];
  logic signed [XW-1:0]      x_d2  [N_O][D_E];
  logic signed [SW-1:0]      sum_c [D_E];
  logic signed [XW-1:0]      mean_c[D_E];
  logic signed [XW-1:0]      mean_q[D_E];
  logic signed [GW-1:0]      g_c   [D_E];
  logic signed [GW-1:0]      g_q   [D_E];
  logic signed [FW-1:0]      m_c   [N_O][D_E];
  logic [N_O*D_E*OUT_W-1:0]  sat_c;

  always_comb begin
    for (int i = 0; i < N_O; i++)
      for (int d = 0; d < D_E; d++) begin
        logic signed [FW-1:0] acc;
        acc = '0;
        for (int p = 0; p < P; p++)
          acc = acc + shadd(FW'(signed'(in_feat[(i*P+p)*IN_W +: IN_W])),
                            W1[(d*P+p)*W_W +: W_W]);
        x_c[i][d] = XW'(acc);
      end
  end

  always_comb begin
    for (int d = 0; d < D_E; d++) begin
      logic signed [SW-1:0] acc;
      acc = '0;
      for (int i = 0; i < N_O; i++) acc = acc + SW'(x_q[i][d]);
      sum_c[d]  = acc;
      mean_c[d] = XW'(acc >>> LG_N);
    end
  end

  always_comb begin
    for (int d = 0; d < D_E; d++) begin
      logic signed [FW-1:0] acc;
      acc = '0;
      for (int k = 0; k < D_E; k++)
        acc = acc + shadd(FW'(mean_q[k]), W2[(d*D_E+k)*W_W +: W_W]);
      g_c[d] = GW'(acc);
    end
  end

  always_comb begin
    for (int i = 0; i < N_O; i++)
      for (int d = 0; d < D_E; d++) begin
        m_c[i][d] = FW'(x_d2[i][d]) + FW'(g_q[d]) + FW'(signed'(BIAS[d*B_W +: B_W]));
        if (m_c[i][d] > SAT_HI)      sat_c[(i*D_E+d)*OUT_W +: OUT_W] = OUT_W'(SAT_HI);
        else if (m_c[i][d] < SAT_LO) sat_c[(i*D_E+d)*OUT_W +: OUT_W] = OUT_W'(SAT_LO);
        else                         sat_c[(i*D_E+d)*OUT_W +: OUT_W] = OUT_W'(m_c[i][d]);
      end
  end

  always_ff @(posedge clk) begin
    x_q    <= x_c;
    x_d1   <= x_q;
    x_d2   <= x_d1;
    mean_q <= mean_c;
    g_q    <= g_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= '0;
      out_emb <= '0;
    end else begin
      v_q     <= {v_q[LAT-2:0], in_valid};
      out_emb <= sat_c;
    end
  end

  assign out_valid = v_q[LAT-1];

  logic [$clog2(LAT+1)-1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != LAT) warm <= warm + 1'b1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (warm == LAT) |-> (out_valid == $past(in_valid, 4))); // R7

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_emb == '0)); // R8

  for (genvar d = 0; d < D_E; d++) begin : g_mean_chk
    AST_MEAN_FLOOR: assert property (@(posedge clk) disable iff (rst)
      (warm >= 2) |-> ((SW'(mean_q[d]) <<< LG_N) <= $past(sum_c[d]) &&
                       $past(sum_c[d]) - (SW'(mean_q[d]) <<< LG_N) < N_O)); // R2
  end

  for (genvar i = 0; i < N_O; i++) begin : g_node_chk
    for (genvar d = 0; d < D_E; d++) begin : g_lane_chk
      AST_X_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (warm >= 3) |-> (x_d2[i][d] == $past(x_q[i][d], 2))); // R4
      AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (warm >= 1 && $past(m_c[i][d] > SAT_HI)) |->
        (out_emb[(i*D_E+d)*OUT_W +: OUT_W] == {1'b0, {(OUT_W-1){1'b1}}})); // R5
      AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
        (warm >= 1 && $past(m_c[i][d] < SAT_LO)) |->
        (out_emb[(i*D_E+d)*OUT_W +: OUT_W] == {1'b1, {(OUT_W-1){1'b0}}})); // R5
    end
  end
endmodule

// File: tb/test_graph_ctx_layer.sv
`timescale 1ns/1ps
module test_graph_ctx_layer;
  localparam int LAT = 4;
  localparam int NV  = 8;
  localparam logic [63:0] VEC [NV] = '{
    64'h0000000000000000,
    64'h0102030405060708,
    64'hFFFEFDFC0A0B0C0D,
    64'h0000000000000005,
    64'h7F7F7F7F7F7F7F7F,
    64'h8080808080808080,
    64'h00000000000000FF,
    64'h10F020E030D040C0
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_feat;
  logic        out_valid;
  logic [79:0] out_emb;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  graph_ctx_layer i_graph_ctx_layer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_feat(in_feat),
    .out_valid(out_valid), .out_emb(out_emb)
  );

  function automatic logic [79:0] model(input logic [63:0] f);
    int w1 [2][2] = '{'{3, -2}, '{1, 5}};
    int w2 [2][2] = '{'{2, -1}, '{-3, 4}};
    int cb [2]    = '{5, -7};
    int x [4][2];
    int s [2];
    int m [2];
    int g [2];
    logic [79:0] r;
    for (int d = 0; d < 2; d++) s[d] = 0;
    for (int i = 0; i < 4; i++)
      for (int d = 0; d < 2; d++) begin
        x[i][d] = 0;
        for (int p = 0; p < 2; p++)
          x[i][d] += w1[d][p] * int'($signed(f[(i*2+p)*8 +: 8]));
        s[d] += x[i][d];
      end
    for (int d = 0; d < 2; d++) m[d] = s[d] >>> 2;
    for (int d = 0; d < 2; d++) g[d] = w2[d][0]*m[0] + w2[d][1]*m[1];
    for (int i = 0; i < 4; i++)
      for (int d = 0; d < 2; d++) begin
        int e;
        e = x[i][d] + g[d] + cb[d];
        if (e > 511) e = 511;
        if (e < -512) e = -512;
        r[(i*2+d)*10 +: 10] = 10'(e);
      end
    return r;
  endfunction

  function automatic logic [79:0] pack4(input int e00, input int e01,
                                         input int e10, input int e11);
    logic [79:0] r;
    r[9:0]   = 10'(e00); r[19:10] = 10'(e01);
    for (int i = 1; i < 4; i++) begin
      r[(i*2)*10 +: 10]   = 10'(e10);
      r[(i*2+1)*10 +: 10] = 10'(e11);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act,
                     input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_feat = '0;
    repeat (3) @(negedge clk);
    chk(!out_valid && out_emb == '0, "R8 reset state", {79'd0, out_valid} | out_emb, '0);
    rst = 1'b0;

    // R6 back-to-back table walk; each result also covers R1 R3 R4 R5
    for (int k = 0; k < NV + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT)
        chk(out_valid && out_emb == model(VEC[k-LAT]), "R6 R1 R3 R4 R5 stream",
            out_emb, model(VEC[k-LAT]));
      if (k < NV) begin in_valid = 1'b1; in_feat = VEC[k]; end
      else in_valid = 1'b0;
    end
    @(negedge clk);
    chk(!out_valid, "R7 idle after stream", {79'd0, out_valid}, '0);

    // R7 latency of a single pulse, R2 floor of a negative sum
    in_valid = 1'b1; in_feat = VEC[6];
    for (int t = 1; t <= 5; t++) begin
      @(negedge clk);
      chk(out_valid == (t == 4), "R7 valid timing", {79'd0, out_valid}, {79'd0, t == 4});
      if (t == 4)
        chk(out_emb == pack4(1, -9, 4, -8), "R2 floor toward -inf", out_emb, pack4(1, -9, 4, -8));
      in_valid = 1'b0;
    end

    // R4 one active node moves all nodes through the shared context
    in_valid = 1'b1; in_feat = VEC[3];
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid && out_emb == pack4(25, -7, 10, -12), "R4 broadcast", out_emb,
        pack4(25, -7, 10, -12));

    // R5 saturation in both directions on one graph each
    in_valid = 1'b1; in_feat = VEC[4];
    @(negedge clk);
    in_feat = VEC[5];
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_emb[19:10] == 10'd511 && out_emb[9:0] == 10'(-376), "R5 high clamp",
        out_emb, model(VEC[4]));
    @(negedge clk);
    chk(out_emb[19:10] == 10'h200 && out_emb[9:0] == 10'd389, "R5 low clamp",
        out_emb, model(VEC[5]));

    // R8 reset while data is in flight
    in_valid = 1'b1; in_feat = VEC[1];
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!out_valid && out_emb == '0, "R8 mid-stream reset", out_emb, '0);
    rst = 1'b0; in_valid = 1'b0;
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      chk(!out_valid, "R7 nothing after reset flush", {79'd0, out_valid}, '0);
    end

    finish_run();
  end
endmodule